// File: doc/BRIEF.md
# Oversampled Asynchronous Character Receiver

This block turns an asynchronous serial line into whole characters. The line idles high. A character begins with a low start bit. The data bits follow, least significant first. An optional parity bit may come next, and a single stop bit ends the character. The receiver does not generate its baud rate. An outside divider supplies an enable pulse, `os_tick`, at sixteen times the bit rate, and all line timing is counted in those pulses.

Each character is stored with two flags: one for a parity mismatch and one for a low stop bit. Characters wait in a small first-in first-out store until the consumer removes the oldest one with a one-cycle pop. Three static inputs set the frame shape: a seven-bit data mode, parity enable and parity sense. The sender may use one stop bit or two. Only the first stop bit is examined, so a start bit that follows the first stop bit directly is accepted.

Top module: `uart_frame_rx`

## Requirements
- R1: After a synchronous reset, the store is empty (`rd_valid`=0, `rx_level`=0), `rx_full` is 0 and `rx_overrun` is 0.
- R2: In eight-bit mode, the eight bits that follow the start bit are stored least significant first and appear on `rd_data`.
- R3: With `cfg_seven_bit`=1, seven data bits are taken and `rd_data[7]` reads 0. Line activity in an eighth data position is not treated as data.
- R4: With parity enabled, the bit after the last data bit is compared with the XOR of the data bits, inverted when `cfg_parity_odd`=1. On a mismatch, `rd_parity_err`=1 is stored with that character.
- R5: With parity disabled, no parity bit is expected and `rd_parity_err` is always 0.
- R6: A stop bit sampled low sets `rd_frame_err`=1 for that character. The character is still stored.
- R7: A falling edge is confirmed at the middle of the start bit. If the line is high there, no character is stored and the receiver waits for the next falling edge.
- R8: A new start bit that directly follows the single stop bit is received as the next character.
- R9: The store holds up to four characters. `rd_data` shows the oldest one, and `rd_pop` removes it. At four entries, `rx_full`=1.
- R10: A character that completes while the store is full, with no pop in the same cycle, is discarded and `rx_overrun` is set. `rx_overrun` stays set until `ovr_clear` is pulsed. A new overrun in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Enable pulse at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_seven_bit | input | 1 | 1: seven data bits, 0: eight |
| cfg_parity_en | input | 1 | 1: a parity bit follows the data |
| cfg_parity_odd | input | 1 | 1: odd parity, 0: even parity |
| rd_pop | input | 1 | Remove the oldest stored character |
| ovr_clear | input | 1 | Clear the overrun flag |
| rd_valid | output | 1 | The store holds at least one character |
| rd_data | output | 8 | Oldest character |
| rd_parity_err | output | 1 | Parity error flag of the oldest character |
| rd_frame_err | output | 1 | Stop-bit error flag of the oldest character |
| rx_level | output | 3 | Number of stored characters |
| rx_full | output | 1 | The store is full |
| rx_overrun | output | 1 | Sticky flag: a character was discarded |

## Verification
The bench uses the default parameters: 16 oversampling ticks per bit, a four-entry store and a two-stage line synchronizer. It drives `os_tick` on every second clock, so one bit lasts 32 clocks. With a store only four deep, the full and overrun paths are reached after five back-to-back characters. With 16 ticks per bit, a start pulse of four ticks is short enough to count as a glitch.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic              perr;
        logic              ferr;
        logic [CHAR_W-1:0] data;
    } rx_char_t;

    // XOR of the data bits, inverted for odd sense
    function automatic logic want_parity(input logic [CHAR_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    // Bits shift in at the top; a short character sits one place too high
    function automatic logic [CHAR_W-1:0] align_char(input logic [CHAR_W-1:0] sh,
                                                     input logic short_mode);
        return short_mode ? {1'b0, sh[CHAR_W-1:1]} : sh;
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], line_in};
    end

    assign line_out = chain[STAGES-1];
endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     line,
    input  logic     seven,
    input  logic     par_en,
    input  logic     par_odd,
    output logic     push,
    output rx_char_t char_out
);
    localparam int CW = $clog2(OVERSAMPLE);
    localparam int BW = $clog2(CHAR_W);
    localparam logic [CW-1:0] CNT_LAST = CW'(OVERSAMPLE - 1);
    localparam logic [CW-1:0] CNT_MID  = CW'(OVERSAMPLE / 2 - 1);

    rx_state_e         state;
    logic [CW-1:0]     cnt;
    logic [BW-1:0]     bit_idx;
    logic [CHAR_W-1:0] shreg;
    logic              par_bit;
    logic              prev_hi;
    logic [BW-1:0]     last_idx;
    logic              at_centre;
    logic [CHAR_W-1:0] word;

    assign last_idx  = seven ? BW'(CHAR_W - 2) : BW'(CHAR_W - 1);
    assign at_centre = tick && (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            prev_hi <= 1'b1;
        end else begin
            if (tick) prev_hi <= line;
            unique case (state)
                RX_IDLE: begin
                    if (tick && prev_hi && !line) begin
                        state   <= RX_START;
                        cnt     <= '0;
                        bit_idx <= '0;
                        shreg   <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (cnt == CNT_MID) begin
                            cnt   <= '0;
                            state <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (at_centre) begin
                        cnt   <= '0;
                        shreg <= {line, shreg[CHAR_W-1:1]};
                        if (bit_idx == last_idx) begin
                            bit_idx <= '0;
                            state   <= par_en ? RX_PAR : RX_STOP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (at_centre) begin
                        cnt     <= '0;
                        par_bit <= line;
                        state   <= RX_STOP;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (at_centre) begin
                        cnt   <= '0;
                        state <= RX_IDLE;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign word          = align_char(shreg, seven);
    assign push          = (state == RX_STOP) && at_centre;
    assign char_out.data = word;
    assign char_out.perr = par_en && (par_bit != want_parity(word, par_odd));
    assign char_out.ferr = !line;

    // R7: a high line seen in idle never leaves idle
    a_r7_idle_on_high: assert property (@(posedge clk) disable iff (rst)
        (state == RX_IDLE && line) |=> (state == RX_IDLE));

    // R8: after a stored character the receiver is hunting for a start edge again
    a_r8_back_to_idle: assert property (@(posedge clk) disable iff (rst)
        push |=> (state == RX_IDLE));

    // R3: the bit counter never runs past the widest character
    a_r3_bit_range: assert property (@(posedge clk) disable iff (rst)
        (state == RX_DATA) |-> (bit_idx <= last_idx));
endmodule

// File: rtl/rx_char_fifo.sv
module rx_char_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  rx_char_t                   wr_char,
    input  logic                       rd_en,
    output rx_char_t                   head,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       empty,
    output logic                       full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

    rx_char_t          mem [DEPTH];
    logic [PW-1:0]     wptr, rptr;
    logic [LW-1:0]     count;
    logic              do_wr, do_rd;

    assign do_rd = rd_en && (count != '0);
    assign do_wr = wr_en && ((count != LW'(DEPTH)) || do_rd);

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_char;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
            if (do_rd) rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rptr];
    assign level = count;
    assign empty = (count == '0);
    assign full  = (count == LW'(DEPTH));

    // R9: occupancy never exceeds the depth
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= LW'(DEPTH));

    // R9: an empty store with no write stays empty whatever the pop does
    a_r9_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && !wr_en) |=> (count == '0));
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
    import uart_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int FIFO_DEPTH  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            os_tick,
    input  logic                            rxd,
    input  logic                            cfg_seven_bit,
    input  logic                            cfg_parity_en,
    input  logic                            cfg_parity_odd,
    input  logic                            rd_pop,
    input  logic                            ovr_clear,
    output logic                            rd_valid,
    output logic [CHAR_W-1:0]               rd_data,
    output logic                            rd_parity_err,
    output logic                            rd_frame_err,
    output logic [$clog2(FIFO_DEPTH+1)-1:0] rx_level,
    output logic                            rx_full,
    output logic                            rx_overrun
);
    logic     line_s;
    logic     push;
    rx_char_t new_char;
    rx_char_t head;
    logic     empty;
    logic     drop;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .line_in  (rxd),
        .line_out (line_s)
    );

    rx_deframer #(.OVERSAMPLE(OVERSAMPLE)) u_deframe (
        .clk      (clk),
        .rst      (rst),
        .tick     (os_tick),
        .line     (line_s),
        .seven    (cfg_seven_bit),
        .par_en   (cfg_parity_en),
        .par_odd  (cfg_parity_odd),
        .push     (push),
        .char_out (new_char)
    );

    rx_char_fifo #(.DEPTH(FIFO_DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (push),
        .wr_char (new_char),
        .rd_en   (rd_pop),
        .head    (head),
        .level   (rx_level),
        .empty   (empty),
        .full    (rx_full)
    );

    assign drop = push && rx_full && !rd_pop;

    always_ff @(posedge clk) begin
        if (rst)            rx_overrun <= 1'b0;
        else if (drop)      rx_overrun <= 1'b1;
        else if (ovr_clear) rx_overrun <= 1'b0;
    end

    assign rd_valid      = !empty;
    assign rd_data       = head.data;
    assign rd_parity_err = head.perr;
    assign rd_frame_err  = head.ferr;

    // R10: the overrun flag holds until cleared
    a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (rx_overrun && !ovr_clear) |=> rx_overrun);

    // R10: a character arriving at a full store without a pop raises overrun
    a_r10_drop_sets: assert property (@(posedge clk) disable iff (rst)
        (push && rx_full && !rd_pop) |=> rx_overrun);
endmodule

// File: tb/sim_uart_frame_rx.sv
module sim_uart_frame_rx;
    localparam int BIT_CLK = 32;   // 16 ticks, one tick every 2 clocks
    localparam int NV = 8;
    // {seven, par_en, odd, flip_parity, stop_low, data[7:0]}
    localparam logic [12:0] VEC [NV] = '{
        {5'b00000, 8'hA5},
        {5'b01000, 8'h3C},
        {5'b01100, 8'h3C},
        {5'b01010, 8'h01},
        {5'b10000, 8'hD5},
        {5'b11100, 8'h7F},
        {5'b00001, 8'h81},
        {5'b11010, 8'h12}
    };

    logic clk = 1'b0;
    logic rst, os_tick, rxd, c7, cpe, cpo, rd_pop, ovr_clear;
    logic rd_valid, rd_parity_err, rd_frame_err, rx_full, rx_overrun;
    logic [7:0] rd_data;
    logic [2:0] rx_level;
    int errors = 0, checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) os_tick <= 1'b0;
        else     os_tick <= ~os_tick;
    end

    uart_frame_rx u0 (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
        .cfg_seven_bit(c7), .cfg_parity_en(cpe), .cfg_parity_odd(cpo),
        .rd_pop(rd_pop), .ovr_clear(ovr_clear), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_parity_err(rd_parity_err),
        .rd_frame_err(rd_frame_err), .rx_level(rx_level),
        .rx_full(rx_full), .rx_overrun(rx_overrun)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        rxd = b;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic seven, input logic pe,
                              input logic odd, input logic flip, input logic stop_lo);
        logic p;
        c7 = seven; cpe = pe; cpo = odd;
        p = (seven ? ^d[6:0] : ^d) ^ odd ^ flip;
        send_bit(1'b0);
        for (int i = 0; i < (seven ? 7 : 8); i++) send_bit(d[i]);
        if (pe) send_bit(p);
        send_bit(!stop_lo);
        rxd = 1'b1;
    endtask

    task automatic pop_one();
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hang expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; rxd = 1'b1; c7 = 0; cpe = 0; cpo = 0; rd_pop = 0; ovr_clear = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid", rd_valid, 0);
        check("R1 level", rx_level, 0);
        check("R1 full", rx_full, 0);
        check("R1 overrun", rx_overrun, 0);
        repeat (BIT_CLK) @(negedge clk);

        // Table walk: R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            logic [12:0] e;
            logic [7:0] xd;
            e = VEC[v];
            send_frame(e[7:0], e[12], e[11], e[10], e[9], e[8]);
            repeat (BIT_CLK) @(negedge clk);
            xd = e[12] ? {1'b0, e[6:0]} : e[7:0];
            check("R2/R3 valid", rd_valid, 1);
            check("R2/R3 data", rd_data, xd);
            check("R4/R5 parity flag", rd_parity_err, e[11] & e[9]);
            check("R6 frame flag", rd_frame_err, e[8]);
            pop_one();
            check("R9 drained", rx_level, 0);
        end

        // R7: a short low pulse is a glitch
        c7 = 0; cpe = 0; cpo = 0;
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BIT_CLK) @(negedge clk);
        check("R7 glitch ignored", rx_level, 0);
        send_frame(8'h6B, 0, 0, 0, 0, 0);
        repeat (BIT_CLK) @(negedge clk);
        check("R7 next char", rd_data, 8'h6B);
        pop_one();

        // R8: back-to-back characters, single stop bit
        send_frame(8'hC3, 0, 1, 1, 0, 0);
        send_frame(8'h5A, 0, 1, 1, 0, 0);
        repeat (BIT_CLK) @(negedge clk);
        check("R8 level", rx_level, 2);
        check("R8 first", rd_data, 8'hC3);
        pop_one();
        check("R8 second", rd_data, 8'h5A);
        check("R8 second perr", rd_parity_err, 0);
        pop_one();

        // R9 R10: fill and overflow
        for (int k = 1; k <= 5; k++) send_frame(8'(k * 17), 0, 0, 0, 0, 0);
        repeat (BIT_CLK) @(negedge clk);
        check("R9 level", rx_level, 4);
        check("R9 full", rx_full, 1);
        check("R10 overrun set", rx_overrun, 1);
        for (int k = 1; k <= 4; k++) begin
            check("R9 order", rd_data, 8'(k * 17));
            pop_one();
        end
        check("R9 empty", rd_valid, 0);
        check("R10 sticky", rx_overrun, 1);
        ovr_clear = 1'b1;
        @(negedge clk);
        ovr_clear = 1'b0;
        @(negedge clk);
        check("R10 cleared", rx_overrun, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule